// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the bus-facing controller of a 512-byte serial EEPROM that answers as a slave on a two-wire I2C bus. It oversamples the bus clock and data lines with the system clock and detects START and STOP conditions. It checks each incoming device address byte against a fixed type code and two strap pins. It acknowledges bytes and shifts read data out by driving an active-high pull-low enable for the open-drain data line.

The controller holds the memory address counter and an internal 512x8 store. It serves byte writes, multi-byte page writes, current-address reads, random reads (a write with no data bytes, then a repeated START and a read) and sequential reads. When a STOP closes a write that carried data, it raises a commit strobe for one cycle to a separate commit engine. While that engine reports busy, no device address is acknowledged, so a master can poll for completion.

Top module: `i2c_ee_slave`

## Requirements
- R1: A START, meaning a falling data line while the clock line is high, is accepted in every state. It aborts any transfer in progress, leaves the store untouched, and makes the next eight bits a device address byte.
- R2: A STOP, meaning a rising data line while the clock line is high, returns the controller to standby with the pull-low enable released. After reset the enable and the commit strobe are both low.
- R3: A device address byte is, MSB first, 1010, the A2 strap, the A1 strap, memory address bit 8, then the direction bit (1 = read, 0 = write). If the type code or either strap bit differs, the byte is not acknowledged.
- R4: In a write, the device address byte, the word address byte (memory address bits 7:0) and every data byte are each acknowledged by holding the data line low through the ninth clock.
- R5: Each data byte is stored at the memory address counter and then the counter increments, so consecutive data bytes in one write fill consecutive addresses.
- R6: A read returns the byte at the counter and increments the counter after each byte. Bit 8 of the counter is loaded from the device address byte of every matched read or write. Bits are sampled on the rising clock edge, and outgoing bits change only after a falling clock edge.
- R7: A write made of a device address and a word address only, followed by a repeated START and a read device address, returns the byte at that word address.
- R8: A read continues with the next byte for as long as the master acknowledges. The counter rolls over from 511 to 0.
- R9: When the master does not acknowledge a read byte, the controller releases the data line and returns to standby.
- R10: While the busy input is high, no device address byte is acknowledged.
- R11: The commit strobe is a single-cycle pulse raised at a STOP that ends a write containing at least one complete data byte. It is not raised after a write with no data bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| pin_a2 | input | 1 | Upper device select strap |
| pin_a1 | input | 1 | Lower device select strap |
| busy_i | input | 1 | Commit engine still writing |
| sda_pull_o | output | 1 | High pulls the data line low |
| commit_o | output | 1 | One-cycle pulse: written data ready to commit |

## Verification
The bench goes after the counter's roll-over from 511 to 0 inside one sequential read. A design that saturates or wraps within a page would return the wrong third byte. It polls right after a write to confirm that the first address is refused while busy, since a design that ignores busy would acknowledge at once. It aborts a data byte halfway with a repeated START and then reads the location back. A design that stored the partial byte or lost the word address would return a wrong value or raise a commit. It also checks that a matched read takes bit 8 of the counter from its device address byte, and that a dummy write raises no commit.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W + 1;
  localparam logic [3:0] TYPE_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXDONE, ST_ACK, ST_TX, ST_MACK
  } ee_state_t;

  typedef enum logic [1:0] {
    K_DEV, K_WADDR, K_DATA
  } ee_kind_t;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [STAGES-1:0][W-1:0] q;
  logic [W-1:0]             prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '1;
      prev <= '1;
    end else begin
      q    <= {q[STAGES-2:0], d};
      prev <= q[STAGES-1];
    end
  end

  assign lvl  = q[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave
  import i2c_ee_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic pin_a2,
  input  logic pin_a1,
  input  logic busy_i,
  output logic sda_pull_o,
  output logic commit_o
);
  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic [1:0] lvl, rise, fall;
  i2c_ee_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q), .d({scl_i, sda_i}),
    .lvl(lvl), .rise(rise), .fall(fall)
  );
  logic scl_hi, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  assign scl_hi    = lvl[1];
  assign sda_s     = lvl[0];
  assign scl_rise  = rise[1];
  assign scl_fall  = fall[1];
  assign start_evt = scl_hi & fall[0];
  assign stop_evt  = scl_hi & rise[0];

  ee_state_t         st, n_st;
  ee_kind_t          kind, n_kind;
  logic [2:0]        bitcnt, n_bit;
  logic [BYTE_W-1:0] sh, n_sh, tx, n_tx, rdata;
  logic [ADDR_W-1:0] addr, n_addr;
  logic              rw, n_rw, pull, n_pull, wrote, n_wrote, n_commit, mem_we;
  logic              dev_ok;

  i2c_ee_store #(.AW(ADDR_W), .DW(BYTE_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(addr), .wdata(sh),
    .raddr(addr), .rdata(rdata)
  );

  assign dev_ok = (sh[7:4] == TYPE_CODE) && (sh[3] == pin_a2) &&
                  (sh[2] == pin_a1) && !busy_i;

  always_comb begin
    n_st = st; n_kind = kind; n_bit = bitcnt; n_sh = sh; n_tx = tx;
    n_addr = addr; n_rw = rw; n_pull = pull; n_wrote = wrote;
    n_commit = 1'b0; mem_we = 1'b0;
    if (start_evt) begin
      n_st = ST_RX; n_kind = K_DEV; n_bit = '0; n_pull = 1'b0;
    end else if (stop_evt) begin
      n_st = ST_IDLE; n_pull = 1'b0;
      if (wrote) begin
        n_commit = 1'b1; n_wrote = 1'b0;
      end
    end else begin
      case (st)
        ST_RX: if (scl_rise) begin
          n_sh = {sh[BYTE_W-2:0], sda_s};
          if (bitcnt == 3'd7) n_st = ST_RXDONE;
          else n_bit = bitcnt + 3'd1;
        end
        ST_RXDONE: if (scl_fall) begin
          case (kind)
            K_DEV: begin
              if (dev_ok) begin
                n_addr = {sh[1], addr[BYTE_W-1:0]};
                n_rw = sh[0]; n_pull = 1'b1; n_st = ST_ACK;
              end else begin
                n_st = ST_IDLE;
              end
            end
            K_WADDR: begin
              n_addr = {addr[ADDR_W-1], sh}; n_pull = 1'b1; n_st = ST_ACK;
            end
            default: begin
              mem_we = 1'b1; n_addr = addr + ADDR_W'(1); n_wrote = 1'b1;
              n_pull = 1'b1; n_st = ST_ACK;
            end
          endcase
        end
        ST_ACK: if (scl_fall) begin
          n_bit = '0;
          if (rw) begin
            n_tx = rdata; n_pull = ~rdata[BYTE_W-1]; n_st = ST_TX;
          end else begin
            n_pull = 1'b0; n_st = ST_RX;
            n_kind = (kind == K_DEV) ? K_WADDR : K_DATA;
          end
        end
        ST_TX: if (scl_fall) begin
          if (bitcnt == 3'd7) begin
            n_pull = 1'b0; n_addr = addr + ADDR_W'(1); n_st = ST_MACK;
          end else begin
            n_bit = bitcnt + 3'd1;
            n_tx = {tx[BYTE_W-2:0], 1'b0};
            n_pull = ~tx[BYTE_W-2];
          end
        end
        ST_MACK: if (scl_rise) begin
          n_st = sda_s ? ST_IDLE : ST_ACK;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st <= ST_IDLE; kind <= K_DEV; bitcnt <= '0; sh <= '0; tx <= '0;
      addr <= '0; rw <= 1'b0; pull <= 1'b0; wrote <= 1'b0; commit_o <= 1'b0;
    end else begin
      st <= n_st; kind <= n_kind; bitcnt <= n_bit; sh <= n_sh; tx <= n_tx;
      addr <= n_addr; rw <= n_rw; pull <= n_pull; wrote <= n_wrote;
      commit_o <= n_commit;
    end
  end

  assign sda_pull_o = pull;

  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_q)
    start_evt |=> (st == ST_RX && bitcnt == 3'd0 && kind == K_DEV)); // R1
  AST_STOP_STANDBY: assert property (@(posedge clk) disable iff (!rst_q)
    (stop_evt && !start_evt) |=> (st == ST_IDLE && !sda_pull_o)); // R2
  AST_PULL_IN_DRIVE: assert property (@(posedge clk) disable iff (!rst_q)
    sda_pull_o |-> (st == ST_ACK || st == ST_TX)); // R4
  AST_TX_HOLDS: assert property (@(posedge clk) disable iff (!rst_q)
    (st == ST_TX && !scl_fall && !start_evt && !stop_evt) |=> $stable(sda_pull_o)); // R6
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_q)
    (st == ST_TX && scl_fall && bitcnt == 3'd7 && addr == ADDR_LAST &&
     !start_evt && !stop_evt) |=> (addr == '0)); // R8
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_q)
    (st == ST_RXDONE && kind == K_DEV && busy_i && scl_fall &&
     !start_evt && !stop_evt) |=> !sda_pull_o); // R10
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_q)
    commit_o |=> !commit_o); // R11
endmodule

// File: tb/i2c_ee_slave_tb.sv
module i2c_ee_slave_tb;
  localparam int H = 8;
  localparam int BUSY_CYC = 400;
  localparam int NVEC = 6;
  localparam logic [16:0] VEC [NVEC] = '{
    {9'h000, 8'h3C}, {9'h001, 8'hA5}, {9'h002, 8'h5A},
    {9'h103, 8'hC3}, {9'h050, 8'h7E}, {9'h0FF, 8'h81}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_pull_o, commit_o;
  wire  sda_line = sda_m & ~sda_pull_o;
  int   n_chk = 0, n_bad = 0, n_commit = 0, cyc = 0;

  always #10 clk = ~clk;

  i2c_ee_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .pin_a2(1'b1), .pin_a1(1'b0), .busy_i(busy),
    .sda_pull_o(sda_pull_o), .commit_o(commit_o)
  );

  initial forever begin
    @(posedge clk);
    if (commit_o) begin
      n_commit++;
      busy <= 1'b1;
      repeat (BUSY_CYC) @(posedge clk);
      busy <= 1'b0;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(); repeat (H) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; hw(); scl_m = 1; hw(); sda_m = 0; hw(); scl_m = 0; hw(); endtask
  task automatic bus_stop(); sda_m = 0; hw(); scl_m = 1; hw(); sda_m = 1; hw(); endtask
  task automatic wbit(input logic b); sda_m = b; hw(); scl_m = 1; hw(); scl_m = 0; hw(); endtask
  task automatic rbit(output logic b);
    sda_m = 1; hw(); scl_m = 1; repeat (H/2) @(negedge clk);
    b = sda_line; repeat (H/2) @(negedge clk); scl_m = 0; hw();
  endtask
  task automatic send(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b); ack = ~b;
  endtask
  task automatic recv(output logic [7:0] v, input logic mack);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    wbit(~mack);
  endtask
  function automatic logic [7:0] dev(input logic b8, input logic rd);
    return {4'b1010, 1'b1, 1'b0, b8, rd};
  endfunction

  // returns number of address attempts until acknowledged
  task automatic poll(output int tries);
    logic a;
    tries = 0;
    do begin
      bus_start(); send(dev(1'b0, 1'b0), a); bus_stop(); tries++;
    end while (!a && tries < 40);
  endtask

  task automatic rand_read(input logic [8:0] ad, input int n, output logic [7:0] d [16]);
    logic a0, a1, a2;
    bus_start(); send(dev(ad[8], 1'b0), a0); send(ad[7:0], a1);
    bus_start(); send(dev(ad[8], 1'b1), a2);
    chk(a0 && a1 && a2, "R7 address acks", {a0, a1, a2}, 3'b111);
    for (int i = 0; i < n; i++) recv(d[i], i != n - 1);
  endtask

  initial begin
    int tries, c0;
    logic a0, a1, a2;
    logic [7:0] rd [16];
    logic [7:0] v;
    repeat (5) @(negedge clk);
    chk(sda_pull_o == 0 && commit_o == 0, "R2 reset outputs", {sda_pull_o, commit_o}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // address mismatches
    bus_start(); send(8'b1011_1000, a0); bus_stop();
    chk(!a0, "R3 wrong type code acked", a0, 0);
    bus_start(); send(8'b1010_0000, a0); bus_stop();
    chk(!a0, "R3 wrong A2 strap acked", a0, 0);
    chk(sda_pull_o == 0, "R2 released after stop", sda_pull_o, 0);

    // vector table: byte write, busy poll, random read back
    for (int k = 0; k < NVEC; k++) begin
      c0 = n_commit;
      bus_start(); send(dev(VEC[k][16], 1'b0), a0);
      send(VEC[k][15:8], a1); send(VEC[k][7:0], a2); bus_stop();
      chk(a0 && a1 && a2, "R4 write acks", {a0, a1, a2}, 3'b111);
      chk(n_commit == c0 + 1, "R11 commit after data write", n_commit - c0, 1);
      poll(tries);
      chk(tries > 1 && tries < 40, "R10 busy refuses address", tries, 2);
      c0 = n_commit;
      rand_read(VEC[k][16:8], 1, rd); bus_stop();
      chk(rd[0] == VEC[k][7:0], "R7 random read data", rd[0], VEC[k][7:0]);
      chk(n_commit == c0, "R11 no commit after dummy write", n_commit - c0, 0);
    end

    // page write of 16 bytes at 0x1F0
    c0 = n_commit;
    bus_start(); send(dev(1'b1, 1'b0), a0); send(8'hF0, a1);
    chk(a0 && a1, "R4 page header acks", {a0, a1}, 2'b11);
    for (int i = 0; i < 16; i++) begin
      send(8'(i * 7 + 3), a2);
      chk(a2, "R4 page data ack", a2, 1);
    end
    bus_stop();
    chk(n_commit == c0 + 1, "R11 single commit per page", n_commit - c0, 1);
    poll(tries);
    rand_read(9'h1F0, 16, rd); bus_stop();
    for (int i = 0; i < 16; i++)
      chk(rd[i] == 8'(i * 7 + 3), "R5 page byte", rd[i], 8'(i * 7 + 3));

    // roll-over 0x1FE, 0x1FF, 0x000
    rand_read(9'h1FE, 3, rd);
    chk(rd[0] == 8'(14 * 7 + 3) && rd[1] == 8'(15 * 7 + 3), "R8 tail bytes",
        {rd[0], rd[1]}, {8'(14 * 7 + 3), 8'(15 * 7 + 3)});
    chk(rd[2] == 8'h3C, "R8 roll-over to 0", rd[2], 8'h3C);
    chk(sda_pull_o == 0, "R9 released after nack", sda_pull_o, 0);
    bus_stop();

    // current-address reads
    bus_start(); send(dev(1'b0, 1'b1), a0); recv(v, 1'b0); bus_stop();
    chk(a0 && v == 8'hA5, "R6 current read 0x001", v, 8'hA5);
    bus_start(); send(dev(1'b0, 1'b1), a0); recv(v, 1'b0); bus_stop();
    chk(a0 && v == 8'h5A, "R6 counter advanced to 0x002", v, 8'h5A);
    bus_start(); send(dev(1'b1, 1'b1), a0); recv(v, 1'b0); bus_stop();
    chk(a0 && v == 8'hC3, "R6 bit8 from address byte", v, 8'hC3);

    // abort a data byte with a repeated START
    c0 = n_commit;
    bus_start(); send(dev(1'b0, 1'b0), a0); send(8'h50, a1);
    wbit(1); wbit(1); wbit(1);
    bus_start(); send(dev(1'b0, 1'b1), a2); recv(v, 1'b0); bus_stop();
    chk(a2 && v == 8'h7E, "R1 abort keeps data and address", v, 8'h7E);
    chk(n_commit == c0, "R1 abort raises no commit", n_commit - c0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end
endmodule